// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a processor and its interrupt sources. One request line cannot be masked and is edge-triggered. A parameterised number of maskable lines are sampled as levels. The block keeps a pending bit for every source and a set of in-service bits. From these it raises a single request toward the processor. That request is raised only when the most important eligible pending source outranks every level currently being serviced. A more urgent source can therefore interrupt a handler that is already running, while less urgent or equally urgent sources wait.

The processor answers with a one-cycle acknowledge. The block returns a vector code naming the granted source, moves that source from pending to in-service, and later retires the most recent level when software issues an end-of-service command. A small command port lets software load the mask bits, turn the global enable on or off, and read the mask and enable state back.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous reset: `cpu_irq` is low, `vec_out` is 0, every mask bit is 1 (masked), the global enable is 0, and no source is pending or in service.
- R2: A rising edge on `nmi_req` is latched as pending. It reaches the processor whatever the global enable and the mask bits are. It outranks every maskable level and carries vector code NUM_LVL (3 in the default build).
- R3: The command `reg_cmd`=0 with `reg_wr` high loads `reg_wdata` into the mask register. A 1 in bit k blocks maskable level k. `reg_rdata[NUM_LVL-1:0]` shows the mask and `reg_rdata[NUM_LVL]` shows the global enable, both from the cycle after the write.
- R4: Command 1 sets and command 2 clears the global enable, and the change is visible on the next clock. While the enable is clear, only the non-maskable source can raise `cpu_irq`.
- R5: A request on a masked level stays pending. It is delivered once its mask bit is cleared.
- R6: When several eligible sources are pending at once, the one with the higher code wins. Maskable level k has code k.
- R7: A `cpu_ack` pulse while `cpu_irq` is high grants the source shown on `vec_out`. The grant clears that source's pending bit and sets its in-service bit.
- R8: A pending eligible source whose code is higher than the highest in-service level raises `cpu_irq` immediately, nesting on top of it.
- R9: A pending source whose code is lower than or equal to the highest in-service level is not forwarded.
- R10: The command `reg_cmd`=3 (end of service) clears the highest in-service bit. A source that was held back by that level is forwarded on the next cycle.
- R11: A `cpu_ack` while `cpu_irq` is low changes nothing.
- R12: A maskable request high for a single clock edge is recorded as pending. It stays pending until it is granted. A new request on the same source in the grant cycle re-marks it pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_req | input | 1 | Non-maskable request, rising-edge sensitive |
| irq_req | input | NUM_LVL | Maskable requests, sampled as levels |
| cpu_irq | output | 1 | Interrupt request to the processor |
| cpu_ack | input | 1 | One-cycle acknowledge from the processor |
| vec_out | output | IDX_W | Code of the winning source, 0 when idle |
| reg_wr | input | 1 | Command strobe |
| reg_cmd | input | 2 | 0 load mask, 1 enable on, 2 enable off, 3 end of service |
| reg_wdata | input | NUM_LVL | New mask value |
| reg_rdata | output | NUM_LVL+1 | {global enable, mask} |

## Verification
The bench builds the block with its default NUM_LVL of 3, which gives four sources and a 2-bit vector code. At this size, every nesting depth from empty up to all four levels stacked is reachable within a few hundred cycles. The directed part walks through masking, enable toggling, preemption, held equal-level requests and a second NMI edge arriving during NMI service. A seeded stretch of random requests, acknowledges and end-of-service commands then drives the in-service stack through arbitrary push and pop orders against the behavioural model.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int CMD_W = 2;

    typedef enum logic [CMD_W-1:0] {
        CMD_MASK_LOAD = 2'd0,
        CMD_EN_ON     = 2'd1,
        CMD_EN_OFF    = 2'd2,
        CMD_SVC_DONE  = 2'd3
    } reg_cmd_e;

    typedef struct packed {
        logic mask_load;
        logic en_on;
        logic en_off;
        logic svc_done;
    } ctrl_op_t;

    function automatic ctrl_op_t decode_op(input logic wr, input logic [CMD_W-1:0] cmd);
        ctrl_op_t op;
        op = '0;
        if (wr) begin
            case (reg_cmd_e'(cmd))
                CMD_MASK_LOAD: op.mask_load = 1'b1;
                CMD_EN_ON:     op.en_on     = 1'b1;
                CMD_EN_OFF:    op.en_off    = 1'b1;
                default:       op.svc_done  = 1'b1;
            endcase
        end
        return op;
    endfunction

endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
    parameter int NUM_LVL = 3,
    localparam int NUM_SRC = NUM_LVL + 1,
    localparam int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               nmi_req,
    input  logic [NUM_LVL-1:0] irq_req,
    input  logic               grant_v,
    input  logic [IDX_W-1:0]   grant_idx,
    output logic [NUM_SRC-1:0] pend_q
);
    logic               nmi_prev_q;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] clr_vec;

    always_comb begin
        set_vec = {nmi_req & ~nmi_prev_q, irq_req};
        clr_vec = '0;
        if (grant_v) clr_vec[grant_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_prev_q <= 1'b0;
            pend_q     <= '0;
        end else begin
            nmi_prev_q <= nmi_req;
            pend_q     <= (pend_q & ~clr_vec) | set_vec;
        end
    end

    // R12
    pend_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !grant_v |=> (($past(pend_q) & ~pend_q) == '0));

    // R2
    nmi_latch_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi_req) |=> pend_q[NUM_SRC-1]);
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import prio_irq_pkg::*;
#(
    parameter int NUM_LVL = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  ctrl_op_t           op,
    input  logic [NUM_LVL-1:0] wdata,
    output logic [NUM_LVL-1:0] mask_q,
    output logic               gie_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            gie_q  <= 1'b0;
        end else begin
            if (op.mask_load) mask_q <= wdata;
            if (op.en_on)     gie_q  <= 1'b1;
            else if (op.en_off) gie_q <= 1'b0;
        end
    end

    // R3
    mask_rb_chk: assert property (@(posedge clk) disable iff (rst)
        op.mask_load |=> (mask_q == $past(wdata)));

    // R4
    gie_on_chk: assert property (@(posedge clk) disable iff (rst)
        op.en_on |=> gie_q);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NUM_LVL = 3,
    localparam int NUM_SRC = NUM_LVL + 1,
    localparam int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_LVL-1:0] mask,
    input  logic               gie,
    input  logic [NUM_SRC-1:0] isr,
    output logic               irq,
    output logic [IDX_W-1:0]   win_idx
);
    logic [NUM_SRC-1:0] elig;
    logic               win_v;
    logic               svc_v;
    logic [IDX_W-1:0]   svc_idx;

    assign elig[NUM_SRC-1] = pend[NUM_SRC-1];

    for (genvar k = 0; k < NUM_LVL; k++) begin : g_elig
        assign elig[k] = pend[k] & ~mask[k] & gie;
    end

    always_comb begin
        win_v   = 1'b0;
        win_idx = '0;
        svc_v   = 1'b0;
        svc_idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i]) begin
                win_v   = 1'b1;
                win_idx = IDX_W'(i);
            end
            if (isr[i]) begin
                svc_v   = 1'b1;
                svc_idx = IDX_W'(i);
            end
        end
        irq = win_v && (!svc_v || (win_idx > svc_idx));
    end
endmodule

// File: rtl/irq_service.sv
module irq_service #(
    parameter int NUM_LVL = 3,
    localparam int NUM_SRC = NUM_LVL + 1,
    localparam int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               grant_v,
    input  logic [IDX_W-1:0]   grant_idx,
    input  logic               svc_done,
    output logic [NUM_SRC-1:0] isr_q
);
    logic [NUM_SRC-1:0] top_bit;
    logic [NUM_SRC-1:0] isr_nxt;

    always_comb begin
        top_bit = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (isr_q[i]) top_bit = NUM_SRC'(1) << i;
        end
        isr_nxt = isr_q;
        if (svc_done) isr_nxt = isr_nxt & ~top_bit;
        if (grant_v)  isr_nxt[grant_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) isr_q <= '0;
        else     isr_q <= isr_nxt;
    end

    // R11
    isr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!grant_v && !svc_done) |=> $stable(isr_q));

    // R7
    isr_grant_chk: assert property (@(posedge clk) disable iff (rst)
        grant_v |=> isr_q[$past(grant_idx)]);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NUM_LVL = 3,
    localparam int NUM_SRC = NUM_LVL + 1,
    localparam int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               nmi_req,
    input  logic [NUM_LVL-1:0] irq_req,
    output logic               cpu_irq,
    input  logic               cpu_ack,
    output logic [IDX_W-1:0]   vec_out,
    input  logic               reg_wr,
    input  logic [CMD_W-1:0]   reg_cmd,
    input  logic [NUM_LVL-1:0] reg_wdata,
    output logic [NUM_LVL:0]   reg_rdata
);
    localparam logic [IDX_W-1:0] NMI_CODE = IDX_W'(NUM_LVL);

    ctrl_op_t           op;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] isr_q;
    logic [NUM_LVL-1:0] mask_q;
    logic               gie_q;
    logic               arb_irq;
    logic [IDX_W-1:0]   win_idx;
    logic               grant_v;

    assign op      = decode_op(reg_wr, reg_cmd);
    assign grant_v = cpu_ack & arb_irq;

    irq_capture #(.NUM_LVL(NUM_LVL)) u_cap (
        .clk(clk), .rst(rst), .nmi_req(nmi_req), .irq_req(irq_req),
        .grant_v(grant_v), .grant_idx(win_idx), .pend_q(pend_q)
    );

    irq_cfg_regs #(.NUM_LVL(NUM_LVL)) u_cfg (
        .clk(clk), .rst(rst), .op(op), .wdata(reg_wdata),
        .mask_q(mask_q), .gie_q(gie_q)
    );

    irq_arbiter #(.NUM_LVL(NUM_LVL)) u_arb (
        .pend(pend_q), .mask(mask_q), .gie(gie_q), .isr(isr_q),
        .irq(arb_irq), .win_idx(win_idx)
    );

    irq_service #(.NUM_LVL(NUM_LVL)) u_svc (
        .clk(clk), .rst(rst), .grant_v(grant_v), .grant_idx(win_idx),
        .svc_done(op.svc_done), .isr_q(isr_q)
    );

    assign cpu_irq   = arb_irq;
    assign vec_out   = arb_irq ? win_idx : '0;
    assign reg_rdata = {gie_q, mask_q};

    // R2
    nmi_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q[NUM_SRC-1] && !isr_q[NUM_SRC-1]) |-> (cpu_irq && vec_out == NMI_CODE));

    // R4
    gie_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!gie_q && cpu_irq) |-> (vec_out == NMI_CODE));

    // R9
    no_lower_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_irq |-> !isr_q[vec_out]);
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
    localparam int NL    = 3;
    localparam int NS    = NL + 1;
    localparam int IW    = 2;
    localparam time TCLK = 20ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          nmi_req = 1'b0;
    logic [NL-1:0] irq_req = '0;
    logic          cpu_irq;
    logic          cpu_ack = 1'b0;
    logic [IW-1:0] vec_out;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_cmd = '0;
    logic [NL-1:0] reg_wdata = '0;
    logic [NL:0]   reg_rdata;

    always #(TCLK/2) clk = ~clk;

    prio_irq_ctrl #(.NUM_LVL(NL)) u0 (
        .clk(clk), .rst(rst), .nmi_req(nmi_req), .irq_req(irq_req),
        .cpu_irq(cpu_irq), .cpu_ack(cpu_ack), .vec_out(vec_out),
        .reg_wr(reg_wr), .reg_cmd(reg_cmd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    // behavioural reference state
    int m_pend[NS];
    int m_isr[NS];
    int m_mask[NL];
    int m_gie;
    int m_nprev;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    done = 0;
    string phase = "R1";

    function automatic void model_eval(output int best, output int irq);
        int top;
        best = -1;
        top  = -1;
        for (int i = 0; i < NS; i++) begin
            if (m_pend[i] != 0 && (i == NL || (m_mask[i] == 0 && m_gie != 0))) best = i;
            if (m_isr[i] != 0) top = i;
        end
        irq = (best >= 0 && best > top) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        int best, irq, top, nedge;
        if (rst) begin
            for (int i = 0; i < NS; i++) begin m_pend[i] = 0; m_isr[i] = 0; end
            for (int i = 0; i < NL; i++) m_mask[i] = 1;
            m_gie = 0;
            m_nprev = 0;
        end else begin
            model_eval(best, irq);
            top = -1;
            for (int i = 0; i < NS; i++) if (m_isr[i] != 0) top = i;
            nedge = (nmi_req && m_nprev == 0) ? 1 : 0;
            m_nprev = nmi_req ? 1 : 0;
            if (cpu_ack && irq != 0) m_pend[best] = 0;
            if (nedge != 0) m_pend[NL] = 1;
            for (int k = 0; k < NL; k++) if (irq_req[k]) m_pend[k] = 1;
            if (reg_wr && reg_cmd == 2'd3 && top >= 0) m_isr[top] = 0;
            if (cpu_ack && irq != 0) m_isr[best] = 1;
            if (reg_wr) begin
                case (reg_cmd)
                    2'd0: for (int k = 0; k < NL; k++) m_mask[k] = reg_wdata[k] ? 1 : 0;
                    2'd1: m_gie = 1;
                    2'd2: m_gie = 0;
                    default: ;
                endcase
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // compare every cycle at the falling edge
    always @(negedge clk) begin
        int best, irq, exp_vec, exp_rd;
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired in phase %s", phase);
            finish_run();
        end
        if (!rst) begin
            model_eval(best, irq);
            exp_vec = (irq != 0) ? best : 0;
            exp_rd = m_gie << NL;
            for (int k = 0; k < NL; k++) exp_rd |= (m_mask[k] << k);
            n_vec++;
            if (int'(cpu_irq) != irq || int'(vec_out) != exp_vec || int'(reg_rdata) != exp_rd) begin
                n_bad++;
                $display("FAIL %s t=%0t irq/vec/rdata actual %0d/%0d/%0h expected %0d/%0d/%0h",
                         phase, $time, cpu_irq, vec_out, reg_rdata, irq, exp_vec, exp_rd);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd(input logic [1:0] c, input logic [NL-1:0] d);
        reg_wr = 1'b1; reg_cmd = c; reg_wdata = d;
        cyc(1);
        reg_wr = 1'b0;
    endtask

    task automatic ack();
        cpu_ack = 1'b1;
        cyc(1);
        cpu_ack = 1'b0;
    endtask

    task automatic pulse(input logic [NL-1:0] r);
        irq_req = r;
        cyc(1);
        irq_req = '0;
    endtask

    initial begin
        int b, q;
        cyc(3);
        rst = 1'b0;
        phase = "R1";  cyc(2);                       // reset state
        phase = "R3";  cmd(2'd0, 3'b101); cyc(1); cmd(2'd0, 3'b000); cyc(1);
        phase = "R4";  pulse(3'b010); cyc(3);        // enable off: held
        cmd(2'd1, '0); cyc(1);                       // enable on: level 1 raised
        phase = "R7";  ack(); cyc(2);
        phase = "R10"; cmd(2'd3, '0); cyc(2);
        phase = "R12"; pulse(3'b001); cyc(2); ack(); cmd(2'd3, '0); cyc(1);
        phase = "R6";  pulse(3'b101); cyc(1); ack(); cyc(1);
        phase = "R9";  pulse(3'b100); cyc(2);        // equal and lower held
        cmd(2'd3, '0); cyc(1); ack(); cmd(2'd3, '0); cyc(1);
        phase = "R8";  ack(); cyc(1); pulse(3'b010); cyc(1); ack(); cyc(1);
        cmd(2'd3, '0); cmd(2'd3, '0); cyc(1);
        phase = "R5";  cmd(2'd0, 3'b100); pulse(3'b100); cyc(3);
        cmd(2'd0, 3'b000); cyc(1); ack(); cmd(2'd3, '0); cyc(1);
        phase = "R2";  cmd(2'd2, '0); cmd(2'd0, 3'b111);
        nmi_req = 1'b1; cyc(2); nmi_req = 1'b0; cyc(1);
        pulse(3'b111); ack(); cyc(1);
        nmi_req = 1'b1; cyc(1); nmi_req = 1'b0; cyc(2);
        cmd(2'd3, '0); cyc(1); ack(); cmd(2'd3, '0); cyc(1);
        phase = "R11"; cpu_ack = 1'b1; cyc(2); cpu_ack = 1'b0; cyc(1);
        phase = "R4";  cmd(2'd1, '0); cyc(2); cmd(2'd0, 3'b000); cyc(1);
        for (int j = 0; j < 3; j++) begin ack(); cyc(1); end
        for (int j = 0; j < 4; j++) cmd(2'd3, '0);
        cyc(2);
        phase = "R10";
        for (int j = 0; j < 400; j++) begin
            int r;
            r = int'($urandom);
            irq_req = ((r & 7) == 0) ? NL'(r >> 3) : '0;
            nmi_req = ((r >> 8) & 31) == 0;
            model_eval(b, q);
            cpu_ack = (q != 0) && (((r >> 13) & 1) != 0);
            reg_wr  = ((r >> 14) & 7) == 0;
            reg_cmd = ((r >> 17) & 3) == 0 ? 2'd0 : (((r >> 19) & 1) != 0 ? 2'd3 : 2'(r >> 20));
            reg_wdata = NL'(r >> 22);
            cyc(1);
        end
        irq_req = '0; nmi_req = 1'b0; cpu_ack = 1'b0; reg_wr = 1'b0;
        cyc(3);
        finish_run();
    end
endmodule